// File: doc/BRIEF.md
# Pulse-Driven Level Restorer with Loss-of-Link Watchdog

This block is the receiving end of a link that sends only edges. A one-cycle set pulse means the far side went high. A one-cycle clear pulse means it went low. The block keeps the last indicated level on its data output until the next pulse arrives, so it acts as a clocked bistable.

A watchdog guards the link. While the active-low enable pin is low, it counts the clock cycles since the last pulse of either kind. The far side sends refresh pulses at a shorter interval than the timeout, so a healthy link that is idle never trips the watchdog. If no pulse arrives for `TIMEOUT_CYC` cycles, the block takes the far side to be dead. It then drives a fail-safe level, chosen by the `SAFE_LEVEL` parameter, and raises a status flag.

Pulses and status here are plain control signals. No data stream is involved, so the block has no valid/ready handshake and no back-pressure.

Top module: `edge_link_rx`

## Requirements
- R1: A set pulse alone, sampled at a rising clock edge, makes `level_out` 1 after that edge.
- R2: A clear pulse alone, sampled at a rising clock edge, makes `level_out` 0 after that edge.
- R3: When set and clear are sampled high together, clear wins and `level_out` becomes 0.
- R4: In a cycle with no pulse and no watchdog expiry, `level_out` keeps its previous value.
- R5: With `wd_off_n` low, `TIMEOUT_CYC` consecutive sampled cycles without a pulse make `level_out` equal `SAFE_LEVEL` and set `link_lost` to 1 after the last of those edges.
- R6: With `wd_off_n` low, after only `TIMEOUT_CYC-1` consecutive pulse-free cycles, `link_lost` is still 0 and `level_out` is unchanged.
- R7: Any sampled pulse clears `link_lost` after that edge. The level carried by the pulse takes effect at the same edge.
- R8: While `wd_off_n` is sampled high, the idle count is cleared, `link_lost` reads 0 and `level_out` is never forced.
- R9: During and after reset, `level_out` equals `SAFE_LEVEL` and `link_lost` is 1 until the first pulse, or until the watchdog is disabled.
- R10: The fail-safe level follows the parameter: `SAFE_LEVEL`=1 forces 1 and `SAFE_LEVEL`=0 forces 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_pls | input | 1 | One-cycle pulse: line went high |
| clr_pls | input | 1 | One-cycle pulse: line went low |
| wd_off_n | input | 1 | Watchdog enable, active low (1 disables the watchdog) |
| level_out | output | 1 | Restored line level |
| link_lost | output | 1 | 1 while the watchdog holds the output at the safe level |

## Verification
The bench drives both safe-level variants side by side. It sweeps every set/clear combination from both held levels, so a swapped priority or a missed hold shows up. Idle runs with the watchdog on range in length from zero up to beyond the timeout. These pin down the exact expiry cycle and separate off-by-one counting from a correct count. The same runs with the watchdog off, and runs that a pulse ends after expiry, show that disabling and pulses both clear the flag, and that the pulse level wins over the safe level.

// File: rtl/edge_link_pkg.sv
package edge_link_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_RISE = 2'd1,
    CMD_FALL = 2'd2
  } line_cmd_e;

  function automatic line_cmd_e decode_cmd(input logic set_i, input logic clr_i);
    if (clr_i)      return CMD_FALL;
    else if (set_i) return CMD_RISE;
    else            return CMD_IDLE;
  endfunction
endpackage

// File: rtl/edge_link_wdog.sv
module edge_link_wdog #(
  parameter int TIMEOUT_CYC = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_pulse,
  input  logic wd_off_n,
  output logic expire,
  output logic lost
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);
  localparam logic [CW-1:0] LAST  = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] idle_q;
  logic          lost_q;

  always_comb expire = !any_pulse && !wd_off_n && (idle_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= LIMIT;
      lost_q <= 1'b1;
    end else if (any_pulse || wd_off_n) begin
      idle_q <= '0;
      lost_q <= 1'b0;
    end else begin
      if (idle_q != LIMIT) idle_q <= idle_q + 1'b1;
      if (expire)          lost_q <= 1'b1;
    end
  end

  assign lost = lost_q;

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q <= LIMIT);
  p_off_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wd_off_n |=> !lost_q);
  p_pulse_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    any_pulse |=> !lost_q);
endmodule

// File: rtl/edge_link_latch.sv
module edge_link_latch
  import edge_link_pkg::*;
#(
  parameter logic SAFE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pls,
  input  logic clr_pls,
  input  logic force_safe,
  output logic level
);
  line_cmd_e cmd;
  logic      level_q;

  always_comb cmd = decode_cmd(set_pls, clr_pls);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= SAFE_LEVEL;
    end else begin
      unique case (cmd)
        CMD_RISE: level_q <= 1'b1;
        CMD_FALL: level_q <= 1'b0;
        default:  if (force_safe) level_q <= SAFE_LEVEL;
      endcase
    end
  end

  assign level = level_q;

  p_set_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (set_pls && !clr_pls) |=> level_q);
  p_clr_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pls |=> !level_q);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_pls && !clr_pls && !force_safe) |=> $stable(level_q));
endmodule

// File: rtl/edge_link_rx.sv
module edge_link_rx #(
  parameter int   TIMEOUT_CYC = 20000,
  parameter logic SAFE_LEVEL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pls,
  input  logic clr_pls,
  input  logic wd_off_n,
  output logic level_out,
  output logic link_lost
);
  logic any_pulse;
  logic expire;

  always_comb any_pulse = set_pls | clr_pls;

  edge_link_wdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
    .clk(clk), .rst_n(rst_n), .any_pulse(any_pulse),
    .wd_off_n(wd_off_n), .expire(expire), .lost(link_lost)
  );

  edge_link_latch #(.SAFE_LEVEL(SAFE_LEVEL)) u_latch (
    .clk(clk), .rst_n(rst_n), .set_pls(set_pls), .clr_pls(clr_pls),
    .force_safe(expire), .level(level_out)
  );

  p_safe_on_loss_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_lost) |-> (level_out == SAFE_LEVEL));
  p_off_no_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_off_n && !set_pls && !clr_pls) |=> $stable(level_out));
endmodule

// File: tb/edge_link_rx_test.sv
module edge_link_rx_test;
  localparam int T = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set_pls = 1'b0, clr_pls = 1'b0, wd_off_n = 1'b0;
  logic lvl_hi, lost_hi, lvl_lo, lost_lo;
  int   n_run = 0, n_fail = 0;

  logic m_lvl [2];
  int   m_cnt [2];
  logic m_lost [2];

  always #5 clk = ~clk;

  edge_link_rx #(.TIMEOUT_CYC(T), .SAFE_LEVEL(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .set_pls(set_pls), .clr_pls(clr_pls),
    .wd_off_n(wd_off_n), .level_out(lvl_hi), .link_lost(lost_hi));
  edge_link_rx #(.TIMEOUT_CYC(T), .SAFE_LEVEL(1'b0)) uut_lo (
    .clk(clk), .rst_n(rst_n), .set_pls(set_pls), .clr_pls(clr_pls),
    .wd_off_n(wd_off_n), .level_out(lvl_lo), .link_lost(lost_lo));

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int v = 0; v < 2; v++) begin
      m_lvl[v] = (v == 0); m_cnt[v] = T; m_lost[v] = 1'b1;
    end
  endtask

  task automatic compare(input string tag);
    check(tag, lvl_hi, m_lvl[0], "level safe=1");
    check(tag, lost_hi, m_lost[0], "flag safe=1");
    check((tag == "R5") ? "R10" : tag, lvl_lo, m_lvl[1], "level safe=0");
    check(tag, lost_lo, m_lost[1], "flag safe=0");
  endtask

  task automatic step(input logic s, input logic c, input logic off_n);
    string tag;
    set_pls = s; clr_pls = c; wd_off_n = off_n;
    tag = (s && c) ? "R3" : c ? "R2" : s ? "R1" : off_n ? "R8" : "R4";
    for (int v = 0; v < 2; v++) begin
      if (s || c) begin
        m_lvl[v] = !c; m_cnt[v] = 0; m_lost[v] = 1'b0;
      end else if (off_n) begin
        m_cnt[v] = 0; m_lost[v] = 1'b0;
      end else if (m_cnt[v] < T) begin
        m_cnt[v]++;
        if (m_cnt[v] == T) begin
          m_lost[v] = 1'b1; m_lvl[v] = (v == 0); tag = "R5";
        end else if (m_cnt[v] == T - 1) tag = "R6";
      end
    end
    @(posedge clk); #2;
    compare(tag);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    #22;
    compare("R9");
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);   // R9: flag held after reset while idle
    // all pulse combos from both held levels
    for (int start = 0; start < 2; start++)
      for (int sc = 0; sc < 4; sc++) begin
        step(start == 1, start == 0, 1'b0);
        step(sc[0], sc[1], 1'b0);
        step(1'b0, 1'b0, 1'b0);
      end
    // idle runs of every length, watchdog on and off, then a closing pulse (R7)
    for (int off = 0; off < 2; off++)
      for (int start = 0; start < 2; start++)
        for (int len = 0; len <= T + 2; len++)
          for (int fin = 0; fin < 3; fin++) begin
            step(start == 1, start == 0, 1'b0);
            for (int k = 0; k < len; k++) step(1'b0, 1'b0, off == 1);
            step(fin == 0 || fin == 2, fin >= 1, 1'b0);
          end
    // disabling after loss clears flag without forcing (R8)
    for (int k = 0; k < T + 1; k++) step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    // reset mid-run restores safe state (R9)
    step(1'b0, 1'b1, 1'b0);
    rst_n = 1'b0; model_reset(); #3;
    compare("R9");
    @(negedge clk); rst_n = 1'b1;
    step(1'b1, 1'b0, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule